// File: doc/BRIEF.md
# SPI Hold Pause Qualifier

This block sits between the raw serial pins of a SPI target and its command engine. It brings the select, serial clock and pause pins into the system clock domain and finds the serial clock edges. It then passes those edges on to the engine as one-cycle strobes, but only while the transfer is not paused. The host can pause a transfer in mid-sequence by pulling the active-low pause pin low while the device stays selected. No clock edge reaches the engine during the pause, so the engine keeps its bit position. When the pause pin returns high, shifting resumes at the point where it stopped.

The pause state may only change while the serial clock is low. A request made while the clock is high waits for the next falling clock edge. The output driver enable is handled differently: it follows the synchronized pause pin directly, whatever the clock level. Deselecting the device ends any pause along with the rest of the sequence.

The system clock must run at least four times faster than the serial clock. Every pin passes through a `STAGES`-deep synchronizer before it is used.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset no strobe is issued, the pause state is clear and `so_en_o` is 0.
- R2: While selected, if the pause pin is low while the serial clock is low, the block pauses at once. While paused, neither rising nor falling clock edges produce a strobe.
- R3: If the pause pin falls while the serial clock is high, the current high phase is unaffected. The pause starts at the next falling clock edge, and that falling edge produces no strobe.
- R4: If the pause pin rises while the serial clock is low, the block resumes at once, and the next rising clock edge produces a strobe.
- R5: If the pause pin rises while the serial clock is high, the block stays paused until the next falling clock edge. That falling edge produces a strobe, and so does every edge after it.
- R6: `so_en_o` is 1 exactly when the synchronized select is low, the synchronized pause pin is high and `eng_so_en_i` is 1, regardless of the serial clock level or the pause state.
- R7: While the device is deselected (select high), no strobes are issued and the pause state is cleared. After reselecting with the pause pin high and the clock low, the next rising edge produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Raw chip select, active low |
| sck_i | input | 1 | Raw serial clock |
| hold_ni | input | 1 | Raw pause pin, active low |
| eng_so_en_i | input | 1 | Output enable requested by the engine |
| sck_rise_o | output | 1 | Qualified rising-edge strobe for the engine |
| sck_fall_o | output | 1 | Qualified falling-edge strobe for the engine |
| so_en_o | output | 1 | Final serial output driver enable |

## Verification
The hardest case to reach is a change of the pause pin during the high phase of the serial clock, followed by the falling edge that carries the deferred change. The resume version of this case must also be covered, where that falling edge is passed through rather than dropped. Directed sequences set up both orders explicitly. A long random walk then toggles one pin at a time, with enough settling time between changes, and a pin-level model predicts the strobe counts and the output enable after every step. The walk also covers deselecting during a pause.

// File: rtl/shg_pkg.sv
package shg_pkg;
  localparam int unsigned PIN_CNT  = 3;
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCK  = 1;
  localparam int unsigned PIN_HOLD = 2;
  // idle levels: deselected, clock low, not paused
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b101;
endpackage

// File: rtl/shg_sync.sv
module shg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/shg_edge.sv
module shg_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/shg_pause.sv
module shg_pause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic rise_o,
  output logic fall_o,
  output logic paused_o
);
  logic paused_q, paused_d;

  // state may only move while the clock is low; a falling edge lands here too
  always_comb begin
    if (cs_n_i)     paused_d = 1'b0;
    else if (sck_i) paused_d = paused_q;
    else            paused_d = ~hold_n_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) paused_q <= 1'b0;
    else         paused_q <= paused_d;
  end

  // strobes gated by the post-edge state
  assign rise_o   = rise_i & ~cs_n_i & ~paused_d;
  assign fall_o   = fall_i & ~cs_n_i & ~paused_d;
  assign paused_o = paused_q;
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic eng_so_en_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic so_en_o
);
  import shg_pkg::*;

  logic [PIN_CNT-1:0] raw_pins, syn_pins;
  logic s_cs_n, s_sck, s_hold_n;
  logic sck_rise, sck_fall;
  logic paused_q;

  always_comb begin
    raw_pins           = '0;
    raw_pins[PIN_CS]   = cs_ni;
    raw_pins[PIN_SCK]  = sck_i;
    raw_pins[PIN_HOLD] = hold_ni;
  end

  shg_sync #(.STAGES(STAGES), .WIDTH(PIN_CNT), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_pins), .q_o(syn_pins)
  );

  assign s_cs_n   = syn_pins[PIN_CS];
  assign s_sck    = syn_pins[PIN_SCK];
  assign s_hold_n = syn_pins[PIN_HOLD];

  shg_edge #(.RST_VAL(PIN_IDLE[PIN_SCK])) u_edge (
    .clk_i, .rst_ni, .lvl_i(s_sck), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  shg_pause u_pause (
    .clk_i, .rst_ni,
    .cs_n_i(s_cs_n), .sck_i(s_sck), .hold_n_i(s_hold_n),
    .rise_i(sck_rise), .fall_i(sck_fall),
    .rise_o(sck_rise_o), .fall_o(sck_fall_o), .paused_o(paused_q)
  );

  // driver follows the pause pin directly, not the deferred state
  assign so_en_o = eng_so_en_i & ~s_cs_n & s_hold_n;
endmodule

// File: rtl/shg_checker.sv
module shg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic s_cs_n,
  input logic s_sck,
  input logic s_hold_n,
  input logic paused_q,
  input logic eng_so_en_i,
  input logic sck_rise_o,
  input logic sck_fall_o,
  input logic so_en_o
);
  p_desel_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_cs_n |-> (!sck_rise_o && !sck_fall_o));
  p_desel_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_cs_n |=> !paused_q);
  p_no_rise_paused_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_o |-> !paused_q);
  p_low_tracks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_cs_n && !s_sck) |=> (paused_q == !$past(s_hold_n)));
  p_high_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_cs_n && s_sck) |=> $stable(paused_q));
  p_fall_resume_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_fall_o |=> !paused_q);
  p_so_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_hold_n || s_cs_n) |-> !so_en_o);
  p_so_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_cs_n && s_hold_n && eng_so_en_i) |-> so_en_o);
endmodule

bind spi_hold_gate shg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_cs_n(s_cs_n), .s_sck(s_sck),
  .s_hold_n(s_hold_n), .paused_q(paused_q), .eng_so_en_i(eng_so_en_i),
  .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o), .so_en_o(so_en_o)
);

// File: tb/spi_hold_gate_test.sv
module spi_hold_gate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, eng = 1'b0;
  logic rise, fall, so_en;
  int checks = 0, errors = 0;
  int act_r = 0, act_f = 0, exp_r = 0, exp_f = 0;
  bit m_paused = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_hold_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .hold_ni(hold_n),
    .eng_so_en_i(eng), .sck_rise_o(rise), .sck_fall_o(fall), .so_en_o(so_en)
  );

  always @(negedge clk) if (rst_n) begin
    if (rise) act_r++;
    if (fall) act_f++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_so();
    return !cs_n && hold_n && eng;
  endfunction

  // one pin change, then settle; bench model follows the requirements
  task automatic step(input int pin, input bit v);
    bit old_sck = sck;
    @(posedge clk); #1;
    case (pin)
      0: cs_n = v;
      1: sck = v;
      2: hold_n = v;
      default: eng = v;
    endcase
    if (cs_n) m_paused = 0;
    else begin
      if (pin == 1 && !old_sck && sck && !m_paused) exp_r++;
      if (!sck) m_paused = !hold_n;
      if (pin == 1 && old_sck && !sck && !m_paused) exp_f++;
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic cmp(input string tag);
    chk(act_r == exp_r, {tag, " rise"}, act_r, exp_r);
    chk(act_f == exp_f, {tag, " fall"}, act_f, exp_f);
    chk(so_en == exp_so(), {tag, " so_en"}, so_en, exp_so());
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    chk(act_r == 0 && act_f == 0, "R1 strobes", act_r + act_f, 0);
    chk(so_en == 0, "R1 so_en", so_en, 0);

    step(3, 1); step(0, 0);
    step(1, 1); step(1, 0);
    cmp("R7 select");
    // R2: pause with clock low, edges dropped
    step(2, 0);
    chk(so_en == 0, "R6 so_en off at hold", so_en, 0);
    step(1, 1); step(1, 0); step(1, 1); step(1, 0);
    chk(act_r == 1 && act_f == 1, "R2 paused edges", act_r + act_f, 2);
    // R4: resume with clock low
    step(2, 1); step(1, 1);
    chk(act_r == 2, "R4 resume rise", act_r, 2);
    // R3: pause requested in high phase
    step(2, 0);
    chk(so_en == 0, "R6 so_en off high", so_en, 0);
    step(1, 0);
    chk(act_f == 1, "R3 deferred fall dropped", act_f, 1);
    step(1, 1);
    chk(act_r == 2, "R3 rise dropped", act_r, 2);
    // R5: resume requested in high phase
    step(2, 1);
    chk(so_en == 1, "R6 so_en back high", so_en, 1);
    chk(act_r == 2, "R5 no rise yet", act_r, 2);
    step(1, 0);
    chk(act_f == 2, "R5 resuming fall passes", act_f, 2);
    step(1, 1);
    chk(act_r == 3, "R5 later rise", act_r, 3);
    step(1, 0);
    // R7: deselect during pause clears it
    step(2, 0); step(0, 1); step(2, 1); step(0, 0);
    step(1, 1);
    chk(act_r == 4, "R7 reselect rise", act_r, 4);
    step(1, 0);
    cmp("R2 R3 R4 R5 directed");

    for (int i = 0; i < 400; i++) begin
      int p = $urandom_range(0, 9);
      int pin = (p < 5) ? 1 : (p < 8) ? 2 : (p < 9) ? 0 : 3;
      bit cur = (pin == 0) ? cs_n : (pin == 1) ? sck : (pin == 2) ? hold_n : eng;
      step(pin, !cur);
      cmp("R2 R3 R4 R5 R6 R7 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule